// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This block forms the second operand of a 32-bit data-processing instruction together with the carry that the shifter produces. It takes the instruction word, the Rm and Rs register values, one flag for each of them that marks it as the program counter, and the current carry flag. From these it returns the shifted or rotated operand, the shifter carry and a request for one extra execute cycle. The register file and the ALU sit outside the block.

The instruction selects one of three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is Rm shifted by a 5-bit amount taken from the instruction. The third is Rm shifted by the low byte of Rs. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. There is also a one-bit rotate through the carry. Most of the logic exists to get the edge amounts exactly right: zero, exactly 32, above 32, and the immediate encodings in which zero stands for something else. The result is registered, so the outputs follow the inputs one clock later.

Top module: `shop_operand_gen`

## Requirements
- R1: Instruction bit 25 set selects the rotated-constant form; otherwise bit 4 set selects a shift amount taken from Rs, and bit 4 clear selects an amount taken from bits 11:7. `extra_cycle_o` is 1 only in the Rs-amount form. All outputs update on the clock edge after the inputs, and they read 0 while reset is held.
- R2: In the Rs-amount form, Rm and Rs are each increased by 4 before use when their program-counter flag is set. In the other forms the flags have no effect.
- R3: In the Rs-amount form, an amount of 0 (Rs bits 7:0) gives Rm unchanged with carry equal to `carry_in`, for every shift kind.
- R4: The shift kind is chosen by bits 6:5 (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right). Logical left by n = 1..31 gives carry = Rm bit 32−n. By 32 it gives 0 with carry = Rm bit 0. Above 32 it gives 0 with carry 0.
- R5: Logical right by n = 1..31 gives carry = Rm bit n−1. By 32 it gives 0 with carry = Rm bit 31. Above 32 it gives 0 with carry 0.
- R6: Arithmetic right by n = 1..31 gives carry = Rm bit n−1. By 32 or more, every result bit and the carry equal Rm bit 31.
- R7: Rotate right from Rs uses amount bits 4:0. If those bits are nonzero, the carry is Rm bit n−1. If they are zero while the byte is nonzero, the result is Rm with carry = Rm bit 31.
- R8: In the immediate-amount form, a zero amount means: logical right by 32 (result 0, carry = bit 31), arithmetic right by 32 (sign fill, carry = sign), and for logical left, Rm unchanged with `carry_in` kept.
- R9: In the immediate-amount form, rotate right with amount 0 is a one-bit rotate through the carry: the result is {carry_in, Rm[31:1]} and the carry is Rm bit 0.
- R10: In the rotated-constant form, bits 7:0 are rotated right by twice bits 11:8. A rotation of 0 keeps `carry_in`; otherwise the carry is bit 31 of the result.
- R11: An immediate amount of 1..31 shifts Rm by that amount, with carry rules identical to the Rs-amount form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of register Rm |
| rs_val_i | input | 32 | Value of register Rs |
| rm_is_pc_i | input | 1 | Rm is the program counter |
| rs_is_pc_i | input | 1 | Rs is the program counter |
| carry_in | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |
| extra_cycle_o | output | 1 | Extra execute cycle request |

## Verification
The assertions check on every cycle the relations that hold for a whole class of inputs. These are: the extra-cycle request, the zero-amount pass-through from Rs, the zeroed result of a logical left shift above 32, the sign fill of a large arithmetic shift, the rotate through the carry, and an unrotated constant. The exact carry bit picked for each amount from 1 to 31 is shown only by the bench. So are the program-counter adjustment and the exactly-32 cases of each shift kind. The bench shows these through directed amounts 0, 1, 31, 32, 33 and 255 and through random instructions compared with its own model.

// File: rtl/shop_pkg.sv
package shop_pkg;
    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;
    localparam int IMM_W  = 5;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_LR = 2'd1,
        SH_AR = 2'd2,
        SH_RR = 2'd3
    } shop_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] operand;
        logic              carry;
        logic              extra;
    } shop_out_t;
endpackage

// File: rtl/shop_amount_dec.sv
module shop_amount_dec
    import shop_pkg::*;
#(
    parameter int PC_STEP = 4
) (
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rm_val_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic              rm_is_pc_i,
    input  logic              rs_is_pc_i,
    output shop_kind_e        kind_o,
    output logic [AMT_W-1:0]  amt_o,
    output logic              rrx_o,
    output logic              by_reg_o,
    output logic [DATA_W-1:0] rm_eff_o
);
    logic [IMM_W-1:0]  imm_amt;
    logic [DATA_W-1:0] rs_eff;

    always_comb begin
        kind_o   = shop_kind_e'(instr_i[6:5]);
        by_reg_o = instr_i[4];
        imm_amt  = instr_i[11:7];
        rm_eff_o = rm_val_i;
        rs_eff   = rs_val_i;
        rrx_o    = 1'b0;
        amt_o    = '0;
        if (by_reg_o) begin
            if (rm_is_pc_i) rm_eff_o = rm_val_i + DATA_W'(PC_STEP);
            if (rs_is_pc_i) rs_eff   = rs_val_i + DATA_W'(PC_STEP);
            amt_o = rs_eff[AMT_W-1:0];
        end else if (imm_amt != '0) begin
            amt_o = AMT_W'(imm_amt);
        end else begin
            unique case (kind_o)
                SH_LR, SH_AR: amt_o = AMT_W'(DATA_W);
                SH_RR:        rrx_o = 1'b1;
                default:      amt_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
    import shop_pkg::*;
(
    input  shop_kind_e        kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              rrx_i,
    input  logic [DATA_W-1:0] rm_i,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W:0]     amt_c;
    logic [SH_W-1:0]   rot;
    logic [DATA_W:0]   left_x;
    logic [DATA_W:0]   right_x;
    logic [DATA_W:0]   arith_x;
    logic [DATA_W-1:0] ror_v;
    logic              over;

    always_comb begin
        over    = amt_i > AMT_W'(DATA_W);
        amt_c   = over ? (SH_W+1)'(DATA_W) : amt_i[SH_W:0];
        rot     = amt_i[SH_W-1:0];
        left_x  = {1'b0, rm_i} << amt_c;
        right_x = {rm_i, 1'b0} >> amt_c;
        arith_x = $unsigned($signed({rm_i, 1'b0}) >>> amt_c);
        ror_v   = (rm_i >> rot) | (rm_i << ((SH_W+1)'(DATA_W) - {1'b0, rot}));

        res_o   = rm_i;
        carry_o = carry_in;
        if (rrx_i) begin
            res_o   = {carry_in, rm_i[DATA_W-1:1]};
            carry_o = rm_i[0];
        end else if (amt_i != '0) begin
            unique case (kind_i)
                SH_LL: begin
                    res_o   = over ? '0 : left_x[DATA_W-1:0];
                    carry_o = over ? 1'b0 : left_x[DATA_W];
                end
                SH_LR: begin
                    res_o   = over ? '0 : right_x[DATA_W:1];
                    carry_o = over ? 1'b0 : right_x[0];
                end
                SH_AR: begin
                    res_o   = arith_x[DATA_W:1];
                    carry_o = arith_x[0];
                end
                default: begin
                    res_o   = ror_v;
                    carry_o = ror_v[DATA_W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/shop_imm_rot.sv
module shop_imm_rot
    import shop_pkg::*;
(
    input  logic [31:0]       instr_i,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   rot;
    logic [DATA_W-1:0] base;

    always_comb begin
        rot     = SH_W'({instr_i[11:8], 1'b0});
        base    = DATA_W'(instr_i[7:0]);
        res_o   = (base >> rot) | (base << ((SH_W+1)'(DATA_W) - {1'b0, rot}));
        carry_o = (rot == '0) ? carry_in : res_o[DATA_W-1];
    end
endmodule

// File: rtl/shop_operand_gen.sv
module shop_operand_gen
    import shop_pkg::*;
#(
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rm_val_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic              rm_is_pc_i,
    input  logic              rs_is_pc_i,
    input  logic              carry_in,
    output logic [DATA_W-1:0] operand_o,
    output logic              carry_o,
    output logic              extra_cycle_o
);
    shop_kind_e        kind;
    logic [AMT_W-1:0]  amt;
    logic              rrx;
    logic              by_reg;
    logic [DATA_W-1:0] rm_eff;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic [DATA_W-1:0] im_res;
    logic              im_carry;
    shop_out_t         out_d;
    shop_out_t         out_q;

    shop_amount_dec #(.PC_STEP(PC_STEP)) u_dec (
        .instr_i    (instr_i),
        .rm_val_i   (rm_val_i),
        .rs_val_i   (rs_val_i),
        .rm_is_pc_i (rm_is_pc_i),
        .rs_is_pc_i (rs_is_pc_i),
        .kind_o     (kind),
        .amt_o      (amt),
        .rrx_o      (rrx),
        .by_reg_o   (by_reg),
        .rm_eff_o   (rm_eff)
    );

    shop_shift_core u_core (
        .kind_i   (kind),
        .amt_i    (amt),
        .rrx_i    (rrx),
        .rm_i     (rm_eff),
        .carry_in (carry_in),
        .res_o    (sh_res),
        .carry_o  (sh_carry)
    );

    shop_imm_rot u_imm (
        .instr_i  (instr_i),
        .carry_in (carry_in),
        .res_o    (im_res),
        .carry_o  (im_carry)
    );

    // R1: operand form select and extra-cycle request
    always_comb begin
        if (instr_i[25]) begin
            out_d.operand = im_res;
            out_d.carry   = im_carry;
            out_d.extra   = 1'b0;
        end else begin
            out_d.operand = sh_res;
            out_d.carry   = sh_carry;
            out_d.extra   = by_reg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign operand_o     = out_q.operand;
    assign carry_o       = out_q.carry;
    assign extra_cycle_o = out_q.extra;
endmodule

// File: rtl/shop_operand_chk.sv
module shop_operand_chk
    import shop_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] rm_val_i,
    input logic [DATA_W-1:0] rs_val_i,
    input logic              rm_is_pc_i,
    input logic              rs_is_pc_i,
    input logic              carry_in,
    input logic [DATA_W-1:0] operand_o,
    input logic              carry_o,
    input logic              extra_cycle_o
);
    logic              armed_q;
    logic [DATA_W-1:0] rs_adj;
    logic [DATA_W-1:0] rm_adj;
    logic              shf_reg;
    logic              shf_imm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign rs_adj  = rs_is_pc_i ? rs_val_i + 32'd4 : rs_val_i;
    assign rm_adj  = rm_is_pc_i ? rm_val_i + 32'd4 : rm_val_i;
    assign shf_reg = !instr_i[25] && instr_i[4];
    assign shf_imm = !instr_i[25] && !instr_i[4];

    p_extra_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> extra_cycle_o == $past(shf_reg));

    p_zero_amount_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(shf_reg && rs_adj[7:0] == 8'd0)
        |-> operand_o == $past(rm_adj) && carry_o == $past(carry_in));

    p_lsl_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(shf_reg && instr_i[6:5] == 2'd0 && rs_adj[7:0] > 8'd32)
        |-> operand_o == '0 && !carry_o);

    p_asr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(shf_reg && instr_i[6:5] == 2'd2 && rs_adj[7:0] >= 8'd32)
        |-> operand_o == {DATA_W{$past(rm_adj[31])}} && carry_o == $past(rm_adj[31]));

    p_rrx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(shf_imm && instr_i[6:5] == 2'd3 && instr_i[11:7] == 5'd0)
        |-> operand_o == {$past(carry_in), $past(rm_val_i[31:1])} && carry_o == $past(rm_val_i[0]));

    p_const_norot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(instr_i[25] && instr_i[11:8] == 4'd0)
        |-> operand_o == DATA_W'($past(instr_i[7:0])) && carry_o == $past(carry_in));
endmodule

bind shop_operand_gen shop_operand_chk u_chk (.*);

// File: tb/test_shop_operand_gen.sv
module test_shop_operand_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm = '0;
    logic [31:0] rs = '0;
    logic        rm_pc = 1'b0;
    logic        rs_pc = 1'b0;
    logic        cin = 1'b0;
    logic [31:0] op;
    logic        cout;
    logic        xcyc;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    shop_operand_gen i_shop_operand_gen (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rm_val_i(rm), .rs_val_i(rs),
        .rm_is_pc_i(rm_pc), .rs_is_pc_i(rs_pc), .carry_in(cin),
        .operand_o(op), .carry_o(cout), .extra_cycle_o(xcyc)
    );

    // Expected {extra, carry, operand}
    function automatic logic [33:0] model(logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                                          logic ap, logic bp, logic c);
        logic [31:0] v;
        logic [31:0] r;
        logic        k;
        int          n;
        int          t;
        if (ins[25]) begin
            n = 2 * int'(ins[11:8]);
            v = {24'd0, ins[7:0]};
            r = v;
            for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
            k = (n == 0) ? c : r[31];
            return {1'b0, k, r};
        end
        t = int'(ins[6:5]);
        v = a;
        if (ins[4]) begin
            if (ap) v = a + 32'd4;
            n = int'(bp ? (b + 32'd4) & 32'hFF : b & 32'hFF);
            if (n == 0) return {1'b1, c, v};
        end else begin
            n = int'(ins[11:7]);
            if (n == 0) begin
                if (t == 0) return {1'b0, c, v};
                if (t == 3) return {1'b0, v[0], c, v[31:1]};
                n = 32;
            end
        end
        r = v; k = c;
        if (t == 3) begin
            n = n % 32;
            if (n == 0) k = v[31];
            for (int i = 0; i < n; i++) begin k = r[0]; r = {r[0], r[31:1]}; end
        end else begin
            for (int i = 0; i < n && i < 40; i++) begin
                if (t == 0)      begin k = r[31]; r = {r[30:0], 1'b0}; end
                else if (t == 1) begin k = r[0];  r = {1'b0, r[31:1]}; end
                else             begin k = r[0];  r = {r[31], r[31:1]}; end
            end
        end
        return {ins[4], k, r};
    endfunction

    function automatic string tag(logic [31:0] ins, logic ap, logic bp);
        if (ins[25]) return "R10";
        if (ins[4] && (ap || bp)) return "R2";
        if (!ins[4] && ins[11:7] == 5'd0) return (ins[6:5] == 2'd3) ? "R9" : "R8";
        if (!ins[4]) return "R11";
        case (ins[6:5])
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                         logic ap, logic bp, logic c);
        logic [33:0] e;
        @(negedge clk);
        instr = ins; rm = a; rs = b; rm_pc = ap; rs_pc = bp; cin = c;
        e = model(ins, a, b, ap, bp, c);
        @(negedge clk);
        checks++;
        if ({xcyc, cout, op} !== e) begin
            errors++;
            $display("FAIL %s (R1 extra) instr=%h: got x=%b c=%b op=%h exp x=%b c=%b op=%h",
                     tag(ins, ap, bp), ins, xcyc, cout, op, e[33], e[32], e[31:0]);
        end
    endtask

    function automatic logic [31:0] mk_reg(int t, logic [3:0] rsi);
        return {6'd0, 1'b0, 13'd0, rsi, 1'b0, 2'(t), 1'b1, 4'd2};
    endfunction

    function automatic logic [31:0] mk_imm(int t, int n);
        return {6'd0, 1'b0, 13'd0, 5'(n), 2'(t), 1'b0, 4'd2};
    endfunction

    initial begin
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        checks++;
        if ({xcyc, cout, op} !== 34'd0) begin
            errors++;
            $display("FAIL R1 reset: got %h exp 0", {xcyc, cout, op});
        end
        rst_n = 1'b1;
        // R3..R7 register amounts at edges, both carry values
        for (int t = 0; t < 4; t++)
            for (int j = 0; j < 6; j++) begin
                apply(mk_reg(t, 4'd3), 32'h8000_0001, 32'(amts[j]), 1'b0, 1'b0, 1'b1);
                apply(mk_reg(t, 4'd3), 32'h4000_0002, 32'h100 | 32'(amts[j]), 1'b0, 1'b0, 1'b0);
                apply(mk_reg(t, 4'd3), 32'hC3A5_5A3C, 32'(amts[j]), 1'b0, 1'b0, 1'b0);
            end
        apply(mk_reg(3, 4'd3), 32'h8000_1234, 32'd64, 1'b0, 1'b0, 1'b0);      // R7 low bits zero
        // R8, R9, R11 immediate amounts
        for (int t = 0; t < 4; t++)
            for (int n = 0; n < 32; n += 31) begin
                apply(mk_imm(t, n), 32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
                apply(mk_imm(t, n), 32'h7FFF_FFFE, 32'd0, 1'b0, 1'b0, 1'b0);
                apply(mk_imm(t, 1), 32'hF0F0_0F0F, 32'd0, 1'b0, 1'b0, 1'(n));
            end
        // R2 program counter adjustment
        apply(mk_reg(0, 4'd15), 32'h0000_00FC, 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b1);
        apply(mk_reg(1, 4'd15), 32'hFFFF_FFFC, 32'd0, 1'b1, 1'b1, 1'b0);
        // R10 rotated constant
        apply(32'h0200_00FF, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        apply(32'h0200_01FF, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        apply(32'h0200_0F81, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins;
            ins = $urandom();
            ins[24:12] = '0;
            apply(ins, $urandom(), (i % 2 == 0) ? 32'($urandom_range(0, 40)) : $urandom(),
                  1'($urandom()), 1'($urandom()), 1'($urandom()));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule